// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block sits between a UART transmitter and an infrared transceiver. It takes the transmitter's serial NRZ line (idle high) and, when infrared signalling is switched on, turns every zero-valued bit cell into one short active-high pulse on a separate infrared line. Cells holding a one produce no pulse. When infrared signalling is switched off, the serial line is passed straight through to the wired transmit pin and the infrared line stays low.

Two pulse-width modes are offered. In fractional mode the pulse lasts three of the sixteen oversampling ticks of the bit cell and sits near the centre of the cell. In fixed mode the pulse lasts three periods of a separate reference tick, whatever the bit rate. A fixed-mode pulse starts on the first reference tick after the cell opens and is cut short if the cell ends first. The block finds cell boundaries by counting the 16x tick and realigns on every level change of the serial line. It assumes the transmitter changes the line only in the clock cycle right after a 16x tick.

Top module: `sir_encoder`

## Requirements
- R1: While `sir_en_i` is 0, `txd_o` equals `nrz_i` in the same cycle; while `sir_en_i` is 1, `txd_o` is held at 1.
- R2: `ir_o` is 0 in every cycle after a clock edge at which `sir_en_i` was sampled 0, including in the middle of a frame.
- R3: A bit cell opens on the first 16x tick at which `nrz_i` differs from its value at the previous 16x tick. With no level change, a new cell opens every 16 ticks. Ticks in a cell are numbered 0 to 15, and tick 0 is the opening tick.
- R4: In fractional mode (`lp_sel_i` = 0), a cell holding 0 drives `ir_o` high from one clock after its tick 7 until one clock after its tick 10, so the pulse lasts exactly three 16x tick intervals.
- R5: A cell holding 1 produces no pulse in either mode.
- R6: In fixed mode (`lp_sel_i` = 1), a cell holding 0 raises `ir_o` one clock after the first `lp_tick_i` that comes after the opening tick. It lowers `ir_o` one clock after the third `lp_tick_i` that follows, so the pulse lasts three reference-tick periods whatever the 16x tick rate.
- R7: In fixed mode, a pulse still high when the next cell opens is ended at that opening tick, and `ir_o` goes low one clock later.
- R8: In fixed mode, an `lp_tick_i` that arrives in the same cycle as the opening tick does not start the pulse. The pulse starts on the next reference tick.
- R9: During and right after synchronous active-low reset, `ir_o` is 0.
- R10: `lp_sel_i` picks which width rule drives `ir_o`. It can be changed between frames with no other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nrz_i | input | 1 | Serial NRZ data from the UART transmitter, idle high |
| tick16_i | input | 1 | One-cycle strobe at sixteen times the bit rate |
| lp_tick_i | input | 1 | One-cycle strobe from the fixed-width reference divider |
| sir_en_i | input | 1 | 1 selects infrared signalling |
| lp_sel_i | input | 1 | 0 selects fractional width, 1 selects fixed width |
| txd_o | output | 1 | Wired transmit pin |
| ir_o | output | 1 | Infrared transmit line, active high |

## Verification
The hardest situations to reach from the ports are in fixed mode: a reference tick landing in the same cycle as a cell's opening tick, and a pulse that outlasts its cell. The bench resets both strobe dividers together with equal periods, so that every opening tick meets a reference tick. In a separate run it sets the reference period close to the cell length, so that fixed pulses are cut short by the next cell. A behavioural model, checked on every clock, catches any one-cycle error in where a pulse starts. Counts of pulses and high cycles per frame tie pulse width to the tick rates.

// File: rtl/sir_pkg.sv
// Package: shared types and defaults for the infrared SIR pulse encoder.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package sir_pkg;

    // Width rule chosen by the mode select bit.
    typedef enum logic {
        SIR_W_FRACTION = 1'b0,
        SIR_W_FIXED    = 1'b1
    } sir_width_e;

    // Default geometry of a bit cell and of the pulses.
    localparam int SIR_OVERSAMPLE  = 16;
    localparam int SIR_PULSE_START = 7;
    localparam int SIR_PULSE_TICKS = 3;
    localparam int SIR_LP_TICKS    = 3;

endpackage

// File: rtl/sir_cell_tracker.sv
// Module: sir_cell_tracker
// Follows the position of the oversampling tick inside the current bit cell.
// The phase restarts at 0 whenever the serial level differs from the level
// seen at the previous tick, and it otherwise wraps every OVERSAMPLE ticks.
// Assumes the serial line changes only in the cycle after a tick.
module sir_cell_tracker #(
    parameter int OVERSAMPLE = 16,
    localparam int PH_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            nrz_i,
    output logic [PH_W-1:0] phase_q_o,
    output logic [PH_W-1:0] phase_nxt_o,
    output logic            cell_start_o
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] phase_n;
    logic            level_q;

    // Work out the phase for the current tick and flag a cell opening.
    always_comb begin
        phase_n      = phase_q;
        cell_start_o = 1'b0;
        if (tick_i) begin
            if (nrz_i != level_q) begin
                phase_n = '0;
            end else if (phase_q == PH_LAST) begin
                phase_n = '0;
            end else begin
                phase_n = phase_q + 1'b1;
            end
            cell_start_o = (phase_n == '0);
        end
    end

    // Keep the phase and the level seen at the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            level_q <= 1'b1;
        end else if (tick_i) begin
            phase_q <= phase_n;
            level_q <= nrz_i;
        end
    end

    assign phase_q_o   = phase_q;
    assign phase_nxt_o = phase_n;

endmodule

// File: rtl/sir_frac_pulse.sv
// Module: sir_frac_pulse
// Makes the pulse whose width is a fraction of the bit cell. In a zero cell
// the pulse rises at tick START and falls at tick START+WIDTH, or at the next
// cell opening if that comes first.
// Assumes START+WIDTH < OVERSAMPLE and that phase_i is valid while tick_i is 1.
module sir_frac_pulse #(
    parameter int OVERSAMPLE = 16,
    parameter int START      = 7,
    parameter int WIDTH      = 3,
    localparam int PH_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            tick_i,
    input  logic [PH_W-1:0] phase_i,
    input  logic            bit_i,
    output logic            pulse_o
);

    localparam logic [PH_W-1:0] PH_ON  = PH_W'(START);
    localparam logic [PH_W-1:0] PH_OFF = PH_W'(START + WIDTH);

    logic pulse_q;

    // Raise the pulse at the start tick of a zero cell and drop it at the end tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else if (!en_i) begin
            pulse_q <= 1'b0;
        end else if (tick_i) begin
            if (phase_i == PH_ON) begin
                pulse_q <= ~bit_i;
            end else if ((phase_i == PH_OFF) || (phase_i == '0)) begin
                pulse_q <= 1'b0;
            end
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/sir_fixed_pulse.sv
// Module: sir_fixed_pulse
// Makes the fixed-width pulse counted in reference ticks. A zero cell arms
// the generator at its opening. The next reference tick raises the pulse, and
// the pulse lasts LP_TICKS reference periods. A new cell opening ends the
// pulse early.
// Assumes cell_start_i is a single-cycle strobe.
module sir_fixed_pulse #(
    parameter int LP_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic cell_start_i,
    input  logic bit_i,
    input  logic lp_tick_i,
    output logic pulse_o
);

    localparam int            CNT_W    = (LP_TICKS > 2) ? $clog2(LP_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LP_TICKS - 1);

    logic             armed_q;
    logic             pulse_q;
    logic [CNT_W-1:0] cnt_q;

    // Arm on a zero cell, fire on the next reference tick, count the width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            pulse_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!en_i) begin
            armed_q <= 1'b0;
            pulse_q <= 1'b0;
            cnt_q   <= '0;
        end else if (cell_start_i) begin
            armed_q <= ~bit_i;
            pulse_q <= 1'b0;
            cnt_q   <= '0;
        end else if (lp_tick_i) begin
            if (armed_q) begin
                armed_q <= 1'b0;
                pulse_q <= 1'b1;
                cnt_q   <= '0;
            end else if (pulse_q) begin
                if (cnt_q == CNT_LAST) begin
                    pulse_q <= 1'b0;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/sir_encoder.sv
// Module: sir_encoder (top)
// Infrared SIR transmit encoder. It tracks bit cells from the 16x tick, runs
// the fractional-width and fixed-width pulse generators side by side, and
// registers the selected pulse onto the infrared line. With infrared off, the
// serial line passes through to the wired pin and the infrared line stays low.
// Assumes the serial line changes only in the cycle after a 16x tick.
module sir_encoder #(
    parameter int OVERSAMPLE  = sir_pkg::SIR_OVERSAMPLE,
    parameter int PULSE_START = sir_pkg::SIR_PULSE_START,
    parameter int PULSE_TICKS = sir_pkg::SIR_PULSE_TICKS,
    parameter int LP_TICKS    = sir_pkg::SIR_LP_TICKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nrz_i,
    input  logic tick16_i,
    input  logic lp_tick_i,
    input  logic sir_en_i,
    input  logic lp_sel_i,
    output logic txd_o,
    output logic ir_o
);

    localparam int PH_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;

    sir_pkg::sir_width_e mode;
    logic [PH_W-1:0]     phase_cur;
    logic [PH_W-1:0]     phase_nxt;
    logic                cell_start;
    logic                nm_pulse;
    logic                lp_pulse;
    logic                ir_q;

    assign mode = sir_pkg::sir_width_e'(lp_sel_i);

    sir_cell_tracker #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick16_i),
        .nrz_i        (nrz_i),
        .phase_q_o    (phase_cur),
        .phase_nxt_o  (phase_nxt),
        .cell_start_o (cell_start)
    );

    sir_frac_pulse #(
        .OVERSAMPLE (OVERSAMPLE),
        .START      (PULSE_START),
        .WIDTH      (PULSE_TICKS)
    ) u_frac (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (sir_en_i),
        .tick_i  (tick16_i),
        .phase_i (phase_nxt),
        .bit_i   (nrz_i),
        .pulse_o (nm_pulse)
    );

    sir_fixed_pulse #(
        .LP_TICKS (LP_TICKS)
    ) u_fixed (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (sir_en_i),
        .cell_start_i (cell_start),
        .bit_i        (nrz_i),
        .lp_tick_i    (lp_tick_i),
        .pulse_o      (lp_pulse)
    );

    // Register the selected pulse so the infrared line is free of glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= 1'b0;
        end else begin
            ir_q <= sir_en_i & ((mode == sir_pkg::SIR_W_FIXED) ? lp_pulse : nm_pulse);
        end
    end

    // Wired pin: pass the serial line through when infrared is off, else idle.
    always_comb begin
        txd_o = sir_en_i ? 1'b1 : nrz_i;
    end

    assign ir_o = ir_q;

endmodule

// File: rtl/sir_encoder_chk.sv
// Module: sir_encoder_chk
// Checker bound into sir_encoder. It relates the strobes, the enable and the
// outputs of the separate pulse generators over time.
module sir_encoder_chk #(
    parameter int PH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick16_i,
    input logic            lp_tick_i,
    input logic            sir_en_i,
    input logic            ir_o,
    input logic            nm_pulse,
    input logic            lp_pulse,
    input logic            cell_start,
    input logic [PH_W-1:0] phase_cur
);

    AST_IR_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sir_en_i |=> !ir_o); // R2

    AST_IR_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_o) |-> $past(sir_en_i)); // R2

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick16_i |=> $stable(phase_cur)); // R3

    AST_FRAC_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nm_pulse) |-> $past(tick16_i)); // R4

    AST_FIXED_RISE_ON_LPTICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_pulse) |-> ($past(lp_tick_i) && !$past(cell_start))); // R8

    AST_FIXED_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lp_pulse) |-> $past(lp_tick_i || cell_start || !sir_en_i)); // R7

endmodule

bind sir_encoder sir_encoder_chk #(
    .PH_W (PH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16_i   (tick16_i),
    .lp_tick_i  (lp_tick_i),
    .sir_en_i   (sir_en_i),
    .ir_o       (ir_o),
    .nm_pulse   (nm_pulse),
    .lp_pulse   (lp_pulse),
    .cell_start (cell_start),
    .phase_cur  (phase_cur)
);

// File: tb/tb_sir_encoder.sv
// Bench for sir_encoder: tick generators, a UART-like bit feeder, a
// behavioural model compared on every clock, and directed frame checks.
module tb_sir_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nrz, tick16, lp_tick, sir_en, lp_sel;
    logic txd_o, ir_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sir_encoder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .nrz_i     (nrz),
        .tick16_i  (tick16),
        .lp_tick_i (lp_tick),
        .sir_en_i  (sir_en),
        .lp_sel_i  (lp_sel),
        .txd_o     (txd_o),
        .ir_o      (ir_o)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R9";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    // stimulus controls
    int tdiv = 4;
    int lpdiv = 5;
    bit sync_req = 1'b0;
    bit bitq[$];

    // directed counters
    int rises = 0, hi = 0, run = 0, run_max = 0;
    logic prev_ir = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Strobe generators and bit feeder; line changes right after a 16x tick.
    initial begin
        int tcnt = 0, lcnt = 0, bt = 0;
        tick16 = 1'b0; lp_tick = 1'b0; nrz = 1'b1;
        forever begin
            @(negedge clk);
            if (tick16) begin
                bt++;
                if (bt >= 16) begin
                    bt = 0;
                    nrz = (bitq.size() > 0) ? bitq.pop_front() : 1'b1;
                end
            end
            if (sync_req) begin tcnt = 0; lcnt = 0; sync_req = 1'b0; end
            tcnt++;
            if (tcnt >= tdiv) begin tcnt = 0; tick16 = 1'b1; end else tick16 = 1'b0;
            lcnt++;
            if (lcnt >= lpdiv) begin lcnt = 0; lp_tick = 1'b1; end else lp_tick = 1'b0;
        end
    end

    // Behavioural reference of the requirements, updated at each clock edge.
    int m_prev = 1, m_ph = 0, m_np = 0, m_arm = 0, m_lp = 0, m_lc = 0, m_out = 0;
    always @(posedge clk) begin
        int nxt_out, ph;
        bit cs;
        if (!rst_n) begin
            m_prev = 1; m_ph = 0; m_np = 0; m_arm = 0; m_lp = 0; m_lc = 0; m_out = 0;
        end else begin
            nxt_out = (sir_en && (lp_sel ? m_lp : m_np)) ? 1 : 0;
            cs = 1'b0;
            ph = m_ph;
            if (tick16) begin
                ph = (int'(nrz) != m_prev) ? 0 : (m_ph + 1) % 16;
                m_prev = int'(nrz);
                m_ph = ph;
                cs = (ph == 0);
            end
            if (!sir_en) m_np = 0;
            else if (tick16) begin
                if (ph == 7) m_np = nrz ? 0 : 1;
                else if (ph == 10 || ph == 0) m_np = 0;
            end
            if (!sir_en) begin m_lp = 0; m_arm = 0; m_lc = 0; end
            else if (cs) begin m_lp = 0; m_arm = nrz ? 0 : 1; m_lc = 0; end
            else if (lp_tick) begin
                if (m_arm != 0) begin m_lp = 1; m_arm = 0; m_lc = 0; end
                else if (m_lp != 0) begin
                    if (m_lc == 2) begin m_lp = 0; m_lc = 0; end
                    else m_lc++;
                end
            end
            m_out = nxt_out;
        end
    end

    // Compare outputs a quarter period after each edge and count pulses.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (cmp_on && !done) begin
                chk(cur_req, "ir_o", int'(ir_o), m_out);
                chk("R1", "txd_o", int'(txd_o), sir_en ? 1 : int'(nrz));
            end
            if (ir_o && !prev_ir) rises++;
            if (ir_o) begin
                hi++; run++;
                if (run > run_max) run_max = run;
            end else run = 0;
            prev_ir = ir_o;
        end
    end

    task automatic send_byte(input logic [7:0] b);
        bitq.push_back(1'b0);
        for (int i = 0; i < 8; i++) bitq.push_back(b[i]);
        bitq.push_back(1'b1);
    endtask

    task automatic clr_counts();
        rises = 0; hi = 0; run_max = 0;
    endtask

    task automatic wait_idle();
        wait (bitq.size() == 0);
        repeat (40 * tdiv + 200) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        sir_en = 1'b0; lp_sel = 1'b0;
        repeat (5) @(negedge clk);
        // R9: outputs during reset
        chk("R9", "ir_o in reset", int'(ir_o), 0);
        chk("R9", "txd_o in reset", int'(txd_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        chk("R9", "ir_o after reset", int'(ir_o), 0);

        // R1, R2: infrared off, serial passes through
        cur_req = "R2"; tdiv = 4; clr_counts();
        send_byte(8'h35); wait_idle();
        chk("R2", "high cycles while off", hi, 0);

        // R4, R5: fractional mode, alternating bits
        @(negedge clk); sir_en = 1'b1; lp_sel = 1'b0; cur_req = "R4";
        repeat (20) @(negedge clk); clr_counts();
        send_byte(8'h55); wait_idle();
        chk("R5", "pulses for 0x55", rises, 5);
        chk("R4", "high cycles for 0x55", hi, 60);

        // R3: run of zero cells with no level change, faster ticks
        tdiv = 2; cur_req = "R3"; repeat (40) @(negedge clk); clr_counts();
        send_byte(8'h00); wait_idle();
        chk("R3", "pulses for 0x00", rises, 9);
        chk("R3", "high cycles for 0x00", hi, 54);

        // R6, R10: fixed mode, width from the reference tick
        tdiv = 4; lpdiv = 5; lp_sel = 1'b1; cur_req = "R6";
        repeat (40) @(negedge clk); clr_counts();
        send_byte(8'h0F); wait_idle();
        chk("R6", "pulses for 0x0F fixed", rises, 5);
        chk("R10", "fixed-width high cycles", hi, 75);

        // R6: same reference, slower bit rate, same width
        tdiv = 8; repeat (40) @(negedge clk); clr_counts();
        send_byte(8'h0F); wait_idle();
        chk("R6", "high cycles at slower rate", hi, 75);

        // R7: reference period near the cell length, pulses cut short
        tdiv = 2; lpdiv = 30; cur_req = "R7";
        repeat (60) @(negedge clk); clr_counts();
        send_byte(8'h0F); wait_idle();
        chk("R7", "pulses when truncated", rises, 5);
        chk("R7", "longest pulse within a cell", (run_max <= 32) ? 1 : 0, 1);

        // R8: reference ticks coincide with every opening tick
        tdiv = 4; lpdiv = 4; sync_req = 1'b1; cur_req = "R8";
        repeat (40) @(negedge clk); clr_counts();
        send_byte(8'hF0); wait_idle();
        chk("R8", "pulses with coincident ticks", rises, 5);
        chk("R8", "high cycles with coincident ticks", hi, 60);

        // R2: switch off in the middle of a pulse
        lp_sel = 1'b0; lpdiv = 5; cur_req = "R2";
        repeat (40) @(negedge clk);
        send_byte(8'h00);
        wait (ir_o == 1'b1);
        @(negedge clk); sir_en = 1'b0;
        @(posedge clk); #(CLK_PERIOD / 4);
        chk("R2", "ir_o after mid-frame disable", int'(ir_o), 0);
        clr_counts(); wait_idle();
        chk("R2", "high cycles after disable", hi, 0);
        chk("R1", "txd_o idle while off", int'(txd_o), 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule